// File: doc/BRIEF.md
# Software-Maintained Translation Entry Array

This block stores a 64-entry table of page translations that software fills and inspects one 32-bit word at a time. Each entry is reached by an index operand and a word selector. Word 0 covers the effective page number, the page-size code, a low attribute bit, the valid flag and the owning process ID. Word 1 covers the real page number. Word 2 covers eight upper attribute bits and two permission triplets, one for user mode and one for supervisor mode. The block does not search the table by address and does not translate addresses.

A 32-bit control register sits beside the table. Its low byte is the current process ID. A word-0 write tags the entry with that ID, and a word-0 read copies the entry's ID back into it. Whenever a write changes a mapping that is live, in a way that could leave translations cached elsewhere out of date, the block raises a flush request for one cycle.

Each operation is presented for one cycle on the operation port and completes at that clock edge. Read data, the flush request and the illegal-operation flag are registered and appear in the following cycle.

Top module: `tlb_array`

## Requirements
- R1: After reset every entry reads as all zeros in every word, the control register is zero, and flush_o, illegal_o and rd_valid_o are low.
- R2: Only the low 6 bits of idx_i choose the entry, so index 69 and index 5 reach the same entry.
- R3: A word-0 write loads the following fields. The process ID is taken from the control register's low byte as it stood before the write edge.

  | Field | Source |
  |---|---|
  | Page number | data[31:10] |
  | Valid | data[9] |
  | Low attribute | data[8] |
  | Size code | data[7:4] |
- R4: A word-0 write to an entry that was valid raises flush_o in the next cycle in three cases: the page number changes, the decoded page size grows, or the valid flag is cleared. A code k decodes to 1 KiB·4^k for k ≤ 9, and codes 10 to 15 decode as 4 KiB. A word-0 write to an entry that was invalid never flushes.
- R5: A word-1 write stores data & 0xFFFFFC0F as the real page number. It flushes only if the entry is valid and the stored value changes.
- R6: A word-2 write loads the upper attributes from data[15:8], user read/write/execute from bits 0/1/2 and supervisor read/write/execute from bits 3/4/5. It leaves the valid flag and the low attribute bit unchanged and never flushes.
- R7: A word-0 read returns the page number in bits 31:10, valid in bit 9, the low attribute in bit 8, the size code in bits 7:4 and zeros in bits 3:0. A stored code above 9 reads back as 1.
- R8: A word-0 read replaces the control register's low byte with the entry's process ID. The upper 24 bits are kept.
- R9: A word-1 read returns the stored real page number. A word-2 read returns the upper attributes in bits 15:8 and the permissions in bits 5:0 at their write positions, with every other bit zero.
- R10: Word selector 3 changes no entry, raises no flush and no read data, and pulses illegal_o for one cycle.
- R11: ctrl_wr_en_i loads ctrl_wr_data_i into the control register. If a word-0 read happens in the same cycle, the read's process ID takes the low byte and the written value takes the upper bits.
- R12: rd_data_o and rd_valid_o are updated in the cycle after a legal read, and rd_valid_o is high only in that cycle. Read data reflects all writes completed at earlier edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_write_i | input | 1 | 1 for write, 0 for read |
| word_sel_i | input | 2 | Entry word selector; 3 is illegal |
| idx_i | input | 32 | Index operand; the low 6 bits are used |
| wr_data_i | input | 32 | Write data word |
| ctrl_wr_en_i | input | 1 | Load the control register |
| ctrl_wr_data_i | input | 32 | Control register write value |
| rd_data_o | output | 32 | Registered read word |
| rd_valid_o | output | 1 | rd_data_o holds a fresh read result |
| ctrl_o | output | 32 | Control register; the low byte is the current process ID |
| flush_o | output | 1 | One-cycle request to flush cached translations |
| illegal_o | output | 1 | One-cycle flag for selector 3 |

## Verification
Directed word-0 writes cover each flush case in turn against its neighbours. The sequence is:
- the same mapping again;
- a smaller size;
- a larger size;
- a moved page;
- clearing valid;
- the same writes to an invalid entry.

Together these separate a correct flush rule from one that flushes too often or too rarely. A size code above 9 placed after a 64 KiB page shows whether growth is judged on decoded size rather than on the raw code, and reading that entry back checks the substitution of 1. Word-1 writes that differ only in the masked-off bits separate comparing after the mask from comparing before it.

An aliased index, selector 3 followed by a read-back, and a control write in the same cycle as a word-0 read cover indexing, the no-effect rule and control-register priority. A long run of mixed random operations over a few entries is then compared every cycle against a behavioural model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned PAGE_LSB = 10;
  localparam int unsigned EPN_W    = WORD_W - PAGE_LSB;
  localparam int unsigned PID_W    = 8;
  localparam int unsigned ATTR_W   = 8;
  localparam int unsigned PERM_W   = 3;
  localparam logic [WORD_W-1:0] RPN_KEEP = 32'hFFFF_FC0F;

  typedef enum logic [1:0] {
    SEL_TAG  = 2'd0,
    SEL_REAL = 2'd1,
    SEL_ATTR = 2'd2,
    SEL_BAD  = 2'd3
  } word_sel_e;

  typedef struct packed {
    logic [EPN_W-1:0]  epn;
    logic [3:0]        size;
    logic              attr_lo;
    logic [ATTR_W-1:0] attr_hi;
    logic              valid;
    logic [PID_W-1:0]  pid;
    logic [WORD_W-1:0] rpn;
    logic [PERM_W-1:0] perm_usr;
    logic [PERM_W-1:0] perm_sup;
  } tlb_entry_t;

  // codes above max_code decode as 4 KiB (rank 1)
  function automatic logic [3:0] size_rank(logic [3:0] code, int unsigned max_code);
    return (32'(code) > max_code) ? 4'd1 : code;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_entry_t       wr_entry_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output tlb_entry_t       rd_entry_o
);

  tlb_entry_t         entry_q [ENTRIES];
  logic [ENTRIES-1:0] valid_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        entry_q[g] <= wr_entry_i;
      end
    end
    assign valid_vec[g] = entry_q[g].valid;
  end

  assign rd_entry_o = entry_q[rd_idx_i];

  // with no write strobe no entry's valid flag may change
  p_no_write_no_change_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(valid_vec));

  // at most one entry changes per write
  p_single_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ($countones(valid_vec ^ $past(valid_vec)) <= 1));

endmodule

// File: rtl/tlb_write_merge.sv
module tlb_write_merge
  import tlb_pkg::*;
#(
  parameter int unsigned SIZE_MAX = 9
) (
  input  tlb_entry_t        old_i,
  input  word_sel_e         sel_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [PID_W-1:0]  pid_i,
  output tlb_entry_t        new_o,
  output logic              flush_o
);

  logic [EPN_W-1:0]  epn_in;
  logic [3:0]        size_in;
  logic              valid_in;
  logic [WORD_W-1:0] rpn_in;
  logic              epn_moved;
  logic              size_grew;

  assign epn_in    = data_i[WORD_W-1:PAGE_LSB];
  assign size_in   = data_i[7:4];
  assign valid_in  = data_i[9];
  assign rpn_in    = data_i & RPN_KEEP;
  assign epn_moved = epn_in != old_i.epn;
  assign size_grew = size_rank(size_in, SIZE_MAX) > size_rank(old_i.size, SIZE_MAX);

  always_comb begin
    new_o   = old_i;
    flush_o = 1'b0;
    unique case (sel_i)
      SEL_TAG: begin
        new_o.epn     = epn_in;
        new_o.size    = size_in;
        new_o.attr_lo = data_i[8];
        new_o.valid   = valid_in;
        new_o.pid     = pid_i;
        flush_o       = old_i.valid && (epn_moved || size_grew || !valid_in);
      end
      SEL_REAL: begin
        new_o.rpn = rpn_in;
        flush_o   = old_i.valid && (rpn_in != old_i.rpn);
      end
      SEL_ATTR: begin
        new_o.attr_hi  = data_i[15:8];
        new_o.perm_usr = data_i[2:0];
        new_o.perm_sup = data_i[5:3];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tlb_read_pack.sv
module tlb_read_pack
  import tlb_pkg::*;
#(
  parameter int unsigned SIZE_MAX = 9
) (
  input  tlb_entry_t        entry_i,
  input  word_sel_e         sel_i,
  output logic [WORD_W-1:0] word_o
);

  logic [3:0] size_out;

  // illegal stored code reads back as 1
  assign size_out = (32'(entry_i.size) > SIZE_MAX) ? 4'd1 : entry_i.size;

  always_comb begin
    word_o = '0;
    unique case (sel_i)
      SEL_TAG:  word_o = {entry_i.epn, entry_i.valid, entry_i.attr_lo, size_out, 4'b0000};
      SEL_REAL: word_o = entry_i.rpn;
      SEL_ATTR: word_o = {16'h0000, entry_i.attr_hi, 2'b00, entry_i.perm_sup, entry_i.perm_usr};
      default:  word_o = '0;
    endcase
  end

endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES  = 64,
  parameter int unsigned SIZE_MAX = 9,
  localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic              op_write_i,
  input  logic [1:0]        word_sel_i,
  input  logic [WORD_W-1:0] idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ctrl_wr_en_i,
  input  logic [WORD_W-1:0] ctrl_wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic              flush_o,
  output logic              illegal_o
);

  word_sel_e         sel;
  logic [IDX_W-1:0]  idx;
  logic              sel_ok;
  logic              do_wr;
  logic              do_rd;
  logic              rd_tag;
  tlb_entry_t        cur_entry;
  tlb_entry_t        upd_entry;
  logic              flush_req;
  logic [WORD_W-1:0] rd_word;

  logic [WORD_W-1:0] rd_data_q;
  logic              rd_valid_q;
  logic [WORD_W-1:0] ctrl_q;
  logic              flush_q;
  logic              illegal_q;

  assign sel    = word_sel_e'(word_sel_i);
  assign idx    = idx_i[IDX_W-1:0];
  assign sel_ok = sel != SEL_BAD;
  assign do_wr  = op_valid_i &&  op_write_i && sel_ok;
  assign do_rd  = op_valid_i && !op_write_i && sel_ok;
  assign rd_tag = do_rd && (sel == SEL_TAG);

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (do_wr),
    .wr_idx_i   (idx),
    .wr_entry_i (upd_entry),
    .rd_idx_i   (idx),
    .rd_entry_o (cur_entry)
  );

  tlb_write_merge #(.SIZE_MAX(SIZE_MAX)) u_merge (
    .old_i   (cur_entry),
    .sel_i   (sel),
    .data_i  (wr_data_i),
    .pid_i   (ctrl_q[PID_W-1:0]),
    .new_o   (upd_entry),
    .flush_o (flush_req)
  );

  tlb_read_pack #(.SIZE_MAX(SIZE_MAX)) u_pack (
    .entry_i (cur_entry),
    .sel_i   (sel),
    .word_o  (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      flush_q    <= 1'b0;
      illegal_q  <= 1'b0;
    end else begin
      rd_valid_q <= do_rd;
      flush_q    <= do_wr && flush_req;
      illegal_q  <= op_valid_i && !sel_ok;
      if (do_rd) rd_data_q <= rd_word;
    end
  end

  // word-0 read owns the PID byte over a same-cycle control write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (rd_tag) begin
      ctrl_q <= {(ctrl_wr_en_i ? ctrl_wr_data_i[WORD_W-1:PID_W] : ctrl_q[WORD_W-1:PID_W]),
                 cur_entry.pid};
    end else if (ctrl_wr_en_i) begin
      ctrl_q <= ctrl_wr_data_i;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign ctrl_o     = ctrl_q;
  assign flush_o    = flush_q;
  assign illegal_o  = illegal_q;

  p_flush_after_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(op_valid_i && op_write_i && (word_sel_i != 2'd3) && (word_sel_i != 2'd2)));

  p_illegal_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(op_valid_i && (word_sel_i == 2'd3)));

  p_rd_valid_timing_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(op_valid_i && !op_write_i && (word_sel_i != 2'd3)));

  p_ctrl_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!ctrl_wr_en_i && !rd_tag) |-> $stable(ctrl_o));

  p_attr_keeps_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_wr && sel == SEL_ATTR) |-> (upd_entry.valid == cur_entry.valid));

  p_tag_read_pid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tag |=> (ctrl_o[PID_W-1:0] == $past(cur_entry.pid)));

endmodule

// File: tb/tlb_array_tb_top.sv
module tlb_array_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_write = 1'b0;
  logic [1:0]  word_sel = 2'd0;
  logic [31:0] idx = '0;
  logic [31:0] wr_data = '0;
  logic        ctrl_wr_en = 1'b0;
  logic [31:0] ctrl_wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [31:0] ctrl;
  logic        flush;
  logic        illegal;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  tlb_array dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .op_valid_i     (op_valid),
    .op_write_i     (op_write),
    .word_sel_i     (word_sel),
    .idx_i          (idx),
    .wr_data_i      (wr_data),
    .ctrl_wr_en_i   (ctrl_wr_en),
    .ctrl_wr_data_i (ctrl_wr_data),
    .rd_data_o      (rd_data),
    .rd_valid_o     (rd_valid),
    .ctrl_o         (ctrl),
    .flush_o        (flush),
    .illegal_o      (illegal)
  );

  // behavioural reference
  bit [21:0] m_epn  [64];
  bit [3:0]  m_size [64];
  bit        m_alo  [64];
  bit [7:0]  m_ahi  [64];
  bit        m_val  [64];
  bit [7:0]  m_pid  [64];
  bit [31:0] m_rpn  [64];
  bit [5:0]  m_perm [64];
  bit [31:0] m_ctrl = 0;

  function automatic longint page_bytes(int code);
    longint b = 1024;
    if (code > 9) return 4096;
    repeat (code) b = b * 4;
    return b;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, int sel, bit [31:0] ix, bit [31:0] d,
                      bit cw, bit [31:0] cd, string tag);
    int e = ix % 64;
    bit ex_fl = 0, ex_il = 0, ex_rv = 0;
    bit [31:0] ex_rd = 0;
    bit [31:0] ex_ctrl = m_ctrl;
    op_valid = v; op_write = w; word_sel = 2'(sel); idx = ix; wr_data = d;
    ctrl_wr_en = cw; ctrl_wr_data = cd;
    if (cw) ex_ctrl = cd;
    if (v && sel == 3) ex_il = 1;
    else if (v && w) begin
      if (sel == 0) begin
        if (m_val[e] && ((d >> 10) != m_epn[e] ||
            page_bytes(int'(d[7:4])) > page_bytes(int'(m_size[e])) || !d[9])) ex_fl = 1;
        m_epn[e] = d[31:10]; m_size[e] = d[7:4]; m_alo[e] = d[8];
        m_val[e] = d[9]; m_pid[e] = m_ctrl[7:0];
      end else if (sel == 1) begin
        if (m_val[e] && m_rpn[e] != (d & 32'hFFFFFC0F)) ex_fl = 1;
        m_rpn[e] = d & 32'hFFFFFC0F;
      end else begin
        m_ahi[e] = d[15:8]; m_perm[e] = d[5:0];
      end
    end else if (v) begin
      ex_rv = 1;
      if (sel == 0) begin
        ex_rd = {m_epn[e], 10'h0} | (32'(m_val[e]) << 9) | (32'(m_alo[e]) << 8) |
                (32'((m_size[e] > 9) ? 4'd1 : m_size[e]) << 4);
        ex_ctrl = (ex_ctrl & 32'hFFFFFF00) | 32'(m_pid[e]);
      end else if (sel == 1) ex_rd = m_rpn[e];
      else ex_rd = (32'(m_ahi[e]) << 8) | 32'(m_perm[e]);
    end
    m_ctrl = ex_ctrl;
    @(posedge clk);
    @(negedge clk);
    op_valid = 0; op_write = 0; ctrl_wr_en = 0;
    chk(tag, "flush_o", 32'(flush), 32'(ex_fl));
    chk(tag, "illegal_o", 32'(illegal), 32'(ex_il));
    chk(tag, "rd_valid_o", 32'(rd_valid), 32'(ex_rv));
    chk(tag, "ctrl_o", ctrl, ex_ctrl);
    if (ex_rv) chk(tag, "rd_data_o", rd_data, ex_rd);
  endtask

  task automatic wr(int sel, bit [31:0] ix, bit [31:0] d, string tag);
    step(1, 1, sel, ix, d, 0, 0, tag);
  endtask

  task automatic rd(int sel, bit [31:0] ix, string tag);
    step(1, 0, sel, ix, 0, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ctrl_o", ctrl, 0);
    chk("R1", "flush_o", 32'(flush), 0);
    chk("R1", "illegal_o", 32'(illegal), 0);
    chk("R1", "rd_valid_o", 32'(rd_valid), 0);
    for (int s = 0; s < 3; s++) begin
      rd(s, 0, "R1");
      rd(s, 63, "R1");
    end

    // R11 control write
    step(0, 0, 0, 0, 0, 1, 32'h1234_5678, "R11");

    // R2 aliased index, R3 fields, R4 no flush on invalid entry
    wr(0, 69, 32'hABCD_E000 | (1 << 9) | (1 << 8) | (3 << 4), "R3");
    rd(0, 5, "R2");
    step(0, 0, 0, 0, 0, 1, 32'hAABB_CC00, "R11");
    rd(0, 5, "R8");

    // R4 flush cases on valid entry 5 (size 3)
    wr(0, 5, 32'hABCD_E000 | (1 << 9) | (3 << 4), "R4");
    wr(0, 5, 32'hABCD_E000 | (1 << 9) | (2 << 4), "R4");
    wr(0, 5, 32'hABCD_E000 | (1 << 9) | (4 << 4), "R4");
    wr(0, 5, 32'h1111_1000 | (1 << 9) | (4 << 4), "R4");
    wr(0, 5, 32'h1111_1000 | (4 << 4), "R4");
    wr(0, 5, 32'h2222_2000 | (9 << 4), "R4");

    // R4 decoded size: code 12 after 64 KiB does not grow, then 5 grows
    wr(0, 7, 32'h0000_4000 | (1 << 9) | (3 << 4), "R4");
    wr(0, 7, 32'h0000_4000 | (1 << 9) | (12 << 4), "R4");
    rd(0, 7, "R7");
    wr(0, 7, 32'h0000_4000 | (1 << 9) | (5 << 4), "R4");

    // R5 real page number mask and flush
    wr(1, 9, 32'hFFFF_FFFF, "R5");
    wr(0, 9, 32'h0000_8000 | (1 << 9), "R5");
    wr(1, 9, 32'hFFFF_FC0F, "R5");
    wr(1, 9, 32'h1234_5670, "R5");
    rd(1, 9, "R9");

    // R6 attribute word keeps valid and low attribute
    wr(0, 10, 32'h0000_C000 | (1 << 9) | (1 << 8) | (2 << 4), "R6");
    wr(2, 10, 32'hFFFF_FFFF, "R6");
    rd(2, 10, "R9");
    rd(0, 10, "R6");
    wr(2, 10, 32'h0000_5A15, "R6");
    rd(2, 10, "R9");

    // R10 selector 3 has no effect
    step(1, 1, 3, 10, 32'h0, 0, 0, "R10");
    step(1, 0, 3, 10, 32'h0, 0, 0, "R10");
    rd(0, 10, "R10");
    rd(2, 10, "R10");

    // R11 control write same cycle as word-0 read
    step(1, 0, 0, 10, 0, 1, 32'hDEAD_BEEF, "R11");

    // R12 mixed random traffic over a few entries
    for (int n = 0; n < 600; n++) begin
      int kind = $urandom_range(0, 9);
      int s = $urandom_range(0, 3);
      bit [31:0] ix = 32'($urandom_range(0, 3)) + 32'(64 * $urandom_range(0, 2));
      bit [31:0] d = $urandom;
      bit cw = ($urandom_range(0, 7) == 0);
      step(kind != 9, kind < 5, s, ix, d, cw, $urandom, "R12");
    end

    finish_run();
  end

endmodule